// File: doc/BRIEF.md
# Dual-Channel Interrupt Vector Generator

This block turns the interrupt requests of a two-channel serial peripheral into one active-low interrupt line and an 8-bit vector for the CPU. Each channel reports four request types:

- transmit buffer empty
- external/status change
- received character
- special receive condition

Each type has its own pending flag. A one-cycle pulse from the channel sets the flag, and a per-source strobe clears it.

Software programs two things through a small register write port:

- an 8-bit base vector
- a control byte with a master enable and a vector-modification mode

During an acknowledge cycle, marked by `iack_n` low, the block drives a vector with an output-enable. The vector is either the plain base or the base with bits 3..1 replaced by a 3-bit code. The code names the channel and type of the highest-priority pending request. The code chosen in the first acknowledge cycle is held until the acknowledge ends.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset the base vector is 8'h00, the enable and mode bits are 0, no flag is pending, `int_n` is 1 and `vec_oe` is 0.
- R2: A write with `reg_we`=1 stores `reg_wdata` in the base vector when `reg_sel`=0, or in the control byte when `reg_sel`=1. In the control byte, bit 0 is the master enable and bit 2 is the vector-modification mode.
- R3: A one-cycle pulse on `req_a[i]` or `req_b[i]` sets that pending flag at the next clock edge. `int_n` is 0 from that edge while the enable is 1. Bit index i encodes the type: 0 transmit empty, 1 external/status, 2 received character, 3 special receive.
- R4: A strobe on `clr_a[i]` or `clr_b[i]` clears that flag at the next edge. A request in the same cycle wins over the clear. `int_n` returns to 1 once no flag is pending.
- R5: With the enable at 0, `int_n` stays 1 whatever is pending. Pending flags are kept and assert `int_n` as soon as the enable is set.
- R6: `vec_oe` is 1 exactly while `iack_n` is 0.
- R7: With the mode bit at 0, or the enable at 0, the driven vector equals the base vector.
- R8: With the mode and enable bits at 1, the vector is the base with bits 3..1 replaced by the code {channel A, type[1:0]}. Channel B uses codes 000..011 and channel A uses codes 100..111, where type[1:0] is the bit index i. Bits 7..4 and bit 0 stay as in the base. For example, base 8'hE0 with a channel A received character gives 8'hEC.
- R9: Channel A outranks channel B. Within a channel the order is special receive, then received character, then transmit empty, then external/status.
- R10: The code selected in the first cycle of an acknowledge is held until `iack_n` rises, even if a higher request arrives meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 base vector, 1 control byte |
| reg_wdata | input | 8 | Register write data |
| req_a | input | 4 | Request pulses, channel A, indexed by type |
| req_b | input | 4 | Request pulses, channel B, indexed by type |
| clr_a | input | 4 | Clear strobes, channel A |
| clr_b | input | 4 | Clear strobes, channel B |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| int_n | output | 1 | Active-low interrupt request |
| vec_out | output | 8 | Vector for the data bus |
| vec_oe | output | 1 | Vector output-enable |

## Verification
A table covers all eight codes on two different base vectors, plus several overlapping request sets. Together these expose a design that writes the code into the wrong bit field, corrupts bit 0, swaps the channel bit, or ranks transmit-empty and external/status the wrong way round.

Directed tests target the following faults:
- A design that lets a clear beat a simultaneous request would drop that request.
- A design that erases flags while disabled would never raise `int_n` after the enable is set.
- A design that modifies the vector with the mode bit clear would return the wrong vector.
- A design that re-arbitrates during an acknowledge would change the vector partway through the bus cycle.

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
  parameter int VEC_W  = 8,
  parameter int N_TYPE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [VEC_W-1:0]  reg_wdata,
  input  logic [N_TYPE-1:0] req_a,
  input  logic [N_TYPE-1:0] req_b,
  input  logic [N_TYPE-1:0] clr_a,
  input  logic [N_TYPE-1:0] clr_b,
  input  logic              iack_n,
  output logic              int_n,
  output logic [VEC_W-1:0]  vec_out,
  output logic              vec_oe
);
  localparam int CODE_W = 3;

  logic [VEC_W-1:0]  base;
  logic              ien, mode;
  logic [N_TYPE-1:0] pend_a, pend_b;
  logic              ack_q;
  logic [CODE_W-1:0] held_code, win_code, cur_code;

  function automatic logic [CODE_W-1:0] pick(input logic [N_TYPE-1:0] a,
                                             input logic [N_TYPE-1:0] b);
    if      (a[3]) return 3'b111;
    else if (a[2]) return 3'b110;
    else if (a[0]) return 3'b100;
    else if (a[1]) return 3'b101;
    else if (b[3]) return 3'b011;
    else if (b[2]) return 3'b010;
    else if (b[0]) return 3'b000;
    else if (b[1]) return 3'b001;
    else           return 3'b000;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      ien  <= 1'b0;
      mode <= 1'b0;
    end else if (reg_we) begin
      if (!reg_sel) base <= reg_wdata;
      else begin
        ien  <= reg_wdata[0];
        mode <= reg_wdata[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= '0;
      pend_b <= '0;
    end else begin
      pend_a <= (pend_a & ~clr_a) | req_a;
      pend_b <= (pend_b & ~clr_b) | req_b;
    end
  end

  assign win_code = pick(pend_a, pend_b);
  assign cur_code = ack_q ? held_code : win_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q     <= 1'b0;
      held_code <= '0;
    end else begin
      ack_q <= !iack_n;
      if (!iack_n && !ack_q) held_code <= win_code;
    end
  end

  assign int_n   = !(ien && (|pend_a || |pend_b));
  assign vec_oe  = !iack_n;
  assign vec_out = (mode && ien) ? {base[VEC_W-1:4], cur_code, base[0]} : base;
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [3:0] req_a,
  input logic [3:0] req_b,
  input logic [3:0] clr_a,
  input logic [3:0] clr_b,
  input logic       iack_n,
  input logic       int_n,
  input logic [7:0] vec_out,
  input logic       vec_oe,
  input logic       ien,
  input logic [7:0] base,
  input logic [3:0] pend_a,
  input logic [3:0] pend_b
);
  assert_req_raises_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ien && !reg_we && (|req_a || |req_b)) |=> !int_n);

  assert_clear_drops_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_a & ~req_a) || |(clr_b & ~req_b)) |=>
      (((pend_a & $past(clr_a & ~req_a)) == 4'b0) && ((pend_b & $past(clr_b & ~req_b)) == 4'b0)));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> int_n);

  assert_bus_only_in_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iack_n |-> !vec_oe);

  assert_base_bits_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (vec_out[7:4] == base[7:4] && vec_out[0] == base[0]));

  assert_vector_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!iack_n && $past(!iack_n) && !$past(reg_we)) |-> $stable(vec_out));
endmodule

bind irq_vector_ctl irq_vector_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
  .req_a(req_a), .req_b(req_b), .clr_a(clr_a), .clr_b(clr_b),
  .iack_n(iack_n), .int_n(int_n), .vec_out(vec_out), .vec_oe(vec_oe),
  .ien(ien), .base(base), .pend_a(pend_a), .pend_b(pend_b)
);

// File: tb/irq_vector_ctl_bench.sv
module irq_vector_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {req_a, req_b, base, expected vector}, mode and enable on
  localparam logic [23:0] VECS [NVEC] = '{
    {4'b0100, 4'b0000, 8'hE0, 8'hEC},  // R8 A rx
    {4'b0001, 4'b0000, 8'hE0, 8'hE8},  // R8 A tx
    {4'b0010, 4'b0000, 8'hE0, 8'hEA},  // R8 A ext
    {4'b1000, 4'b0000, 8'hE0, 8'hEE},  // R8 A sp
    {4'b0000, 4'b0001, 8'hE0, 8'hE0},  // R8 B tx
    {4'b0000, 4'b0010, 8'hE0, 8'hE2},  // R8 B ext
    {4'b0000, 4'b0100, 8'h5B, 8'h55},  // R8 B rx, base bits kept
    {4'b0000, 4'b1000, 8'h5B, 8'h57},  // R8 B sp
    {4'b1111, 4'b0000, 8'h00, 8'h0E},  // R9
    {4'b0111, 4'b0000, 8'h00, 8'h0C},  // R9 rx over tx/ext
    {4'b0011, 4'b0000, 8'h00, 8'h08},  // R9 tx over ext
    {4'b0000, 4'b1111, 8'h00, 8'h06},  // R9
    {4'b0010, 4'b1000, 8'h00, 8'h0A},  // R9 A over B
    {4'b0000, 4'b0011, 8'h01, 8'h01}   // R9 B tx over ext
  };

  logic clk = 0, rst_n = 0, reg_we = 0, reg_sel = 0, iack_n = 1;
  logic [7:0] reg_wdata = 0;
  logic [3:0] req_a = 0, req_b = 0, clr_a = 0, clr_b = 0;
  logic int_n, vec_oe;
  logic [7:0] vec_out;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_vector_ctl u_irq_vector_ctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic pulse(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk); req_a = a; req_b = b;
    @(negedge clk); req_a = 0; req_b = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_a = 4'hF; clr_b = 4'hF;
    @(negedge clk); clr_a = 0; clr_b = 0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); iack_n = 0;
    @(posedge clk); #1 v = vec_out;
    @(negedge clk); iack_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    logic [7:0] v;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
    chk("R1 vec_oe", {7'b0, vec_oe}, 8'h00);
    rst_n = 1;
    iack_n = 0; #1;
    chk("R1 base", vec_out, 8'h00);
    chk("R6 oe in ack", {7'b0, vec_oe}, 8'h01);
    @(negedge clk); iack_n = 1; #1;
    chk("R6 oe idle", {7'b0, vec_oe}, 8'h00);

    // R5: pending kept while disabled
    wr(1'b0, 8'hE0);
    pulse(4'b0100, 4'b0000);
    chk("R5 disabled int_n", {7'b0, int_n}, 8'h01);
    wr(1'b1, 8'h01);
    chk("R5 enable shows pending", {7'b0, int_n}, 8'h00);
    ack(v);
    chk("R7 mode clear vector", v, 8'hE0);
    clear_all();
    chk("R4 cleared int_n", {7'b0, int_n}, 8'h01);

    // R2 control write, R3 set
    wr(1'b1, 8'h05);
    pulse(4'b0000, 4'b0010);
    chk("R3 int_n after pulse", {7'b0, int_n}, 8'h00);
    // R4 set wins over clear
    @(negedge clk); req_b = 4'b0001; clr_b = 4'b0011;
    @(negedge clk); req_b = 0; clr_b = 0;
    chk("R4 set wins int_n", {7'b0, int_n}, 8'h00);
    ack(v);
    chk("R4 set wins vector", v, 8'hE0);
    @(negedge clk); clr_b = 4'b0001;
    @(negedge clk); clr_b = 0;
    chk("R4 last clear int_n", {7'b0, int_n}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      clear_all();
      wr(1'b0, VECS[i][15:8]);
      pulse(VECS[i][23:20], VECS[i][19:16]);
      ack(v);
      chk($sformatf("R8/R9 row %0d", i), v, VECS[i][7:0]);
    end

    // R10 hold during ack
    clear_all();
    wr(1'b0, 8'hE0);
    pulse(4'b0000, 4'b0010);
    @(negedge clk); iack_n = 0;
    @(posedge clk); #1 chk("R10 first", vec_out, 8'hE2);
    @(negedge clk); req_a = 4'b1000;
    @(negedge clk); req_a = 0; #1;
    chk("R10 held", vec_out, 8'hE2);
    @(negedge clk); iack_n = 1;
    ack(v);
    chk("R10 next ack", v, 8'hEE);

    // R7 mode off with enable
    wr(1'b1, 8'h01);
    ack(v);
    chk("R7 unmodified", v, 8'hE0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule